// File: doc/BRIEF.md
# Dual-Clock Resettable Line Memory

This block is a line-length buffer with a write port and a read port. Each port has its own clock, and the two clocks need not be related. Each port holds its own address counter. The counter moves only under that port's active-low enable and active-low synchronous clear. No logic compares the two addresses. There are no full or empty indications. The distance between the write address and the read address therefore sets the delay, and that distance is fixed by when each clear is applied and by any cycles in which the read enable is withheld.

The block is used between a producer and a consumer that run at different rates. It is also used as a fixed delay line. If both clears are pulsed together and both enables are held active, each byte comes back exactly one line later. If the read clear is pulsed n cycles after the write clear, the delay is n cycles.

A byte written in one write cycle goes into a staging register and is committed to the array on the next write clock edge. The read port drives a registered byte together with a drive-enable flag that stands in for a tri-state output.

Top module: `lbuf_line_mem`

## Requirements
- R1: When `wr_en_n` is 0 at a rising `wr_clk` edge, `wr_data` is captured for the current write address, and that address advances by one.
- R2: When `wr_en_n` is 1 at a rising `wr_clk` edge, nothing is written and the write address keeps its value, whatever `wr_data` carries.
- R3: When `wr_clr_n` is 0 at a rising `wr_clk` edge, the write address becomes 0 for that edge. If `wr_en_n` is also 0, the byte is stored at address 0 and the counter moves to 1. The clear takes priority over the enable.
- R4: When `rd_en_n` is 1 at a rising `rd_clk` edge, the read address holds. After that edge `rd_drive` is 0 and `rd_data` is 0x00.
- R5: When `rd_en_n` is 0 at a rising `rd_clk` edge, the word at the read address appears on `rd_data` after that edge, `rd_drive` is 1, and the read address advances by one.
- R6: A captured byte is committed to the array at the next `wr_clk` edge. A read of that address at the same moment as the commit still returns the previous content. Whenever reads run one cycle behind writes, each read returns the previous line. A two-cycle lag is the shortest that returns the new byte.
- R7: If both clears are applied at the same edge of a shared clock and both enables stay at 0, each byte reappears on `rd_data` exactly DEPTH (5120) cycles later. A read clear applied n ≥ 2 cycles after the write clear gives an n-cycle delay.
- R8: Both address counters wrap from DEPTH−1 to 0 when they advance without a clear.
- R9: When `rd_clr_n` is 0 at a rising `rd_clk` edge, the read address becomes 0 for that edge. With `rd_en_n` at 0, word 0 is output and the counter moves to 1. With `rd_en_n` at 1, nothing is output and the counter stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_clr_n | input | 1 | Write address clear, active low, synchronous |
| wr_data | input | 8 | Byte to be stored |
| rd_clk | input | 1 | Read-side clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_clr_n | input | 1 | Read address clear, active low, synchronous |
| rd_data | output | 8 | Registered output byte, 0x00 when not driving |
| rd_drive | output | 1 | High when `rd_data` holds a read result (stands in for tri-state) |

## Verification
The two functions that can coincide are the commit of a staged write byte into the array and a read of that same address. This happens whenever the read address trails the write address by exactly one cycle. The bench provokes it by pulsing the read clear one cycle after the write clear, with both ports stepping on one shared clock. Each read then must return the byte from the previous pass through the array, not the byte just captured. The bench judges this against patterns it wrote earlier, and it repeats the case with a two-cycle lag, where the freshly written bytes must appear.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

    localparam int DEF_DEPTH = 5120;
    localparam int DEF_WIDTH = 8;

    // Per-edge action of one port's address counter
    typedef enum logic [1:0] {
        PORT_HOLD      = 2'b00,
        PORT_STEP      = 2'b01,
        PORT_ZERO      = 2'b10,
        PORT_ZERO_STEP = 2'b11
    } port_op_e;

    // Clear has priority over enable; both active low
    function automatic port_op_e decode_op(input logic en_n, input logic clr_n);
        port_op_e op;
        case ({!clr_n, !en_n})
            2'b00:   op = PORT_HOLD;
            2'b01:   op = PORT_STEP;
            2'b10:   op = PORT_ZERO;
            default: op = PORT_ZERO_STEP;
        endcase
        return op;
    endfunction

    function automatic logic op_clears(input port_op_e op);
        return (op == PORT_ZERO) || (op == PORT_ZERO_STEP);
    endfunction

    function automatic logic op_access(input port_op_e op);
        return (op == PORT_STEP) || (op == PORT_ZERO_STEP);
    endfunction

endpackage

// File: rtl/lbuf_addr_ctr.sv
module lbuf_addr_ctr
    import lbuf_pkg::*;
#(
    parameter  int DEPTH = DEF_DEPTH,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en_n,
    input  logic          clr_n,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] acc_addr,
    output logic          acc
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    port_op_e      op;
    logic [AW-1:0] base;
    logic [AW-1:0] nxt;

    always_comb begin
        op   = decode_op(en_n, clr_n);
        base = op_clears(op) ? '0 : cur;
        acc  = op_access(op);
        nxt  = base;
        if (acc) begin
            nxt = (base == LAST) ? '0 : base + 1'b1;
        end
    end

    assign acc_addr = base;

    always_ff @(posedge clk) begin
        cur <= nxt;
    end

endmodule

// File: rtl/lbuf_wr_stage.sv
module lbuf_wr_stage #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          acc,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] din,
    output logic          commit_en,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } stage_t;

    stage_t stg;

    // Captured this edge, committed to the array on the next edge
    always_ff @(posedge clk) begin
        stg <= '{vld: acc, addr: acc_addr, data: din};
    end

    assign commit_en   = stg.vld;
    assign commit_addr = stg.addr;
    assign commit_data = stg.data;

endmodule

// File: rtl/lbuf_dp_array.sv
module lbuf_dp_array #(
    parameter  int DEPTH = 5120,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          rdrive
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        rdrive <= re;
        rdata  <= re ? mem[raddr] : '0;
    end

endmodule

// File: rtl/lbuf_line_mem.sv
module lbuf_line_mem
    import lbuf_pkg::*;
#(
    parameter  int DEPTH = DEF_DEPTH,
    parameter  int DW    = DEF_WIDTH,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_en_n,
    input  logic          wr_clr_n,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_en_n,
    input  logic          rd_clr_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_drive
);
    logic [AW-1:0] wr_addr, wr_acc_addr;
    logic [AW-1:0] rd_addr, rd_acc_addr;
    logic          wr_acc, rd_acc;
    logic          cm_en;
    logic [AW-1:0] cm_addr;
    logic [DW-1:0] cm_data;

    lbuf_addr_ctr #(.DEPTH(DEPTH)) u_wctr (
        .clk      (wr_clk),
        .en_n     (wr_en_n),
        .clr_n    (wr_clr_n),
        .cur      (wr_addr),
        .acc_addr (wr_acc_addr),
        .acc      (wr_acc)
    );

    lbuf_addr_ctr #(.DEPTH(DEPTH)) u_rctr (
        .clk      (rd_clk),
        .en_n     (rd_en_n),
        .clr_n    (rd_clr_n),
        .cur      (rd_addr),
        .acc_addr (rd_acc_addr),
        .acc      (rd_acc)
    );

    lbuf_wr_stage #(.AW(AW), .DW(DW)) u_stage (
        .clk         (wr_clk),
        .acc         (wr_acc),
        .acc_addr    (wr_acc_addr),
        .din         (wr_data),
        .commit_en   (cm_en),
        .commit_addr (cm_addr),
        .commit_data (cm_data)
    );

    lbuf_dp_array #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .wclk   (wr_clk),
        .we     (cm_en),
        .waddr  (cm_addr),
        .wdata  (cm_data),
        .rclk   (rd_clk),
        .re     (rd_acc),
        .raddr  (rd_acc_addr),
        .rdata  (rd_data),
        .rdrive (rd_drive)
    );

endmodule

// File: rtl/lbuf_line_mem_chk.sv
module lbuf_line_mem_chk #(
    parameter  int DEPTH = 5120,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input logic          wr_clk,
    input logic          wr_en_n,
    input logic          wr_clr_n,
    input logic [AW-1:0] wr_addr,
    input logic          rd_clk,
    input logic          rd_en_n,
    input logic          rd_clr_n,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic          rd_drive
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Counters are meaningful only after their first clear
    logic w_seen = 1'b0;
    logic r_seen = 1'b0;

    always_ff @(posedge wr_clk) begin
        if (!wr_clr_n) w_seen <= 1'b1;
    end

    always_ff @(posedge rd_clk) begin
        if (!rd_clr_n) r_seen <= 1'b1;
    end

    AST_WR_STEP: assert property (@(posedge wr_clk) disable iff (!w_seen)
        (!wr_en_n && wr_clr_n && wr_addr != LAST) |=> (wr_addr == $past(wr_addr) + 1'b1)); // R1

    AST_WR_HOLD: assert property (@(posedge wr_clk) disable iff (!w_seen)
        (wr_en_n && wr_clr_n) |=> $stable(wr_addr)); // R2

    AST_WR_CLR_WINS: assert property (@(posedge wr_clk) disable iff (!w_seen)
        (!wr_clr_n && !wr_en_n) |=> (wr_addr == AW'(1))); // R3

    AST_WR_WRAP: assert property (@(posedge wr_clk) disable iff (!w_seen)
        (!wr_en_n && wr_clr_n && wr_addr == LAST) |=> (wr_addr == '0)); // R8

    AST_RD_IDLE_OUT: assert property (@(posedge rd_clk) disable iff (!r_seen)
        rd_en_n |=> (!rd_drive && rd_data == '0)); // R4

    AST_RD_HOLD: assert property (@(posedge rd_clk) disable iff (!r_seen)
        (rd_en_n && rd_clr_n) |=> $stable(rd_addr)); // R4

    AST_RD_DRIVE: assert property (@(posedge rd_clk) disable iff (!r_seen)
        !rd_en_n |=> rd_drive); // R5

    AST_RD_CLR_IDLE: assert property (@(posedge rd_clk) disable iff (!r_seen)
        (!rd_clr_n && rd_en_n) |=> (rd_addr == '0)); // R9

    AST_RD_CLR_WINS: assert property (@(posedge rd_clk) disable iff (!r_seen)
        (!rd_clr_n && !rd_en_n) |=> (rd_addr == AW'(1))); // R9

endmodule

bind lbuf_line_mem lbuf_line_mem_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .wr_clk   (wr_clk),
    .wr_en_n  (wr_en_n),
    .wr_clr_n (wr_clr_n),
    .wr_addr  (wr_addr),
    .rd_clk   (rd_clk),
    .rd_en_n  (rd_en_n),
    .rd_clr_n (rd_clr_n),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_drive (rd_drive)
);

// File: tb/sim_lbuf_line_mem.sv
module sim_lbuf_line_mem;
    localparam int DEPTH = 5120;

    logic       clk = 1'b0;
    logic       wr_en_n = 1'b1, wr_clr_n = 1'b1, rd_en_n = 1'b1, rd_clr_n = 1'b1;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rd_drive;

    // 200 MHz: 5 time units per period
    initial forever begin
        #3 clk = 1'b1;
        #2 clk = 1'b0;
    end

    lbuf_line_mem u0 (
        .wr_clk   (clk),
        .wr_en_n  (wr_en_n),
        .wr_clr_n (wr_clr_n),
        .wr_data  (wr_data),
        .rd_clk   (clk),
        .rd_en_n  (rd_en_n),
        .rd_clr_n (rd_clr_n),
        .rd_data  (rd_data),
        .rd_drive (rd_drive)
    );

    typedef struct {
        logic       oe;
        logic [7:0] d;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    // Requirement-level model of the array and both counters
    logic [7:0] mdl [DEPTH];
    bit         ms_v = 0;
    int         ms_a = 0;
    logic [7:0] ms_d = 8'h00;
    int         mw = 0;
    int         mr = 0;

    function automatic logic [7:0] pf(input int i);
        return 8'((i * 5) ^ (i >> 5));
    endfunction
    function automatic logic [7:0] ph(input int i);
        return 8'((i * 3 + 7) ^ 8'h96);
    endfunction
    function automatic logic [7:0] pk(input int i);
        return 8'(i * 11 + 100);
    endfunction
    function automatic logic [7:0] pm(input int i);
        return 8'(i * 13 + 17);
    endfunction

    task automatic step(input bit wen_n, input bit wclr_n, input logic [7:0] din,
                        input bit ren_n, input bit rclr_n, input string tag,
                        input bit ovr, input logic [7:0] ovr_d);
        int   ra;
        int   wa;
        exp_t e;
        @(negedge clk);
        wr_en_n  = wen_n;
        wr_clr_n = wclr_n;
        wr_data  = din;
        rd_en_n  = ren_n;
        rd_clr_n = rclr_n;
        ra    = rclr_n ? mr : 0;
        e.oe  = !ren_n;
        e.d   = ren_n ? 8'h00 : (ovr ? ovr_d : mdl[ra]);
        e.tag = tag;
        q.push_back(e);
        mr = ren_n ? ra : ((ra == DEPTH - 1) ? 0 : ra + 1);
        if (ms_v) mdl[ms_a] = ms_d;
        wa   = wclr_n ? mw : 0;
        ms_v = !wen_n;
        ms_a = wa;
        ms_d = din;
        mw   = wen_n ? wa : ((wa == DEPTH - 1) ? 0 : wa + 1);
    endtask

    // Monitor: compares each read result one unit after the edge
    initial forever begin
        exp_t e;
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (rd_drive !== e.oe || rd_data !== e.d) begin
                fails++;
                $display("FAIL %s: actual drive=%0b data=%02h expected drive=%0b data=%02h",
                         e.tag, rd_drive, rd_data, e.oe, e.d);
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset state: both clears, no access -> no drive (R4)
        step(1, 0, 8'h00, 1, 0, "R4", 0, 8'h00);
        step(1, 0, 8'h00, 1, 0, "R4", 0, 8'h00);
        // Junk writes to addr 0..2, then a clear while enabled (R1, R3)
        for (int i = 0; i < 3; i++) step(0, 1, 8'hEE, 1, 1, "R1", 0, 8'h00);
        for (int i = 0; i < DEPTH; i++)
            step(0, (i == 0) ? 1'b0 : 1'b1, pf(i), 1, 1, (i == 0) ? "R3" : "R1", 0, 8'h00);
        // Disabled writes carry data that must not land anywhere (R2)
        for (int i = 0; i < 4; i++) step(1, 1, 8'h5A, 1, 1, "R2", 0, 8'h00);
        // Counter wrapped to 0: overwrite addr 0..2 (R8)
        for (int i = 0; i < 3; i++) step(0, 1, 8'hC0 + 8'(i), 1, 1, "R8", 0, 8'h00);
        // Extra clocks to commit the last staged byte (R6)
        step(1, 1, 8'h00, 1, 1, "R6", 0, 8'h00);
        step(1, 1, 8'h00, 1, 1, "R6", 0, 8'h00);
        // Read back the whole line plus a wrap, with a pause (R5, R4, R8, R9)
        for (int i = 0; i < DEPTH + 3; i++) begin
            logic [7:0] x;
            int a;
            a = i % DEPTH;
            x = (a < 3) ? (8'hC0 + 8'(a)) : pf(a);
            if (i == 100)
                for (int k = 0; k < 5; k++) step(1, 1, 8'h00, 1, 1, "R4", 0, 8'h00);
            step(1, 1, 8'h00, 0, (i == 0) ? 1'b0 : 1'b1,
                 (i == 0) ? "R9" : ((i >= DEPTH) ? "R8" : "R5"), 1, x);
        end
        // Clear with read disabled, then read from 0; clear with read enabled
        step(1, 1, 8'h00, 1, 0, "R9", 0, 8'h00);
        step(1, 1, 8'h00, 0, 1, "R9", 1, 8'hC0);
        step(1, 1, 8'h00, 0, 1, "R5", 1, 8'hC1);
        step(1, 1, 8'h00, 0, 0, "R9", 1, 8'hC0);
        step(1, 1, 8'h00, 0, 1, "R9", 1, 8'hC1);
        // One-line delay: both clears together, both enables held (R7)
        for (int i = 0; i < DEPTH + 16; i++) begin
            logic [7:0] x;
            if (i >= DEPTH) x = ph(i - DEPTH);
            else            x = (i < 3) ? (8'hC0 + 8'(i)) : pf(i);
            step(0, (i == 0) ? 1'b0 : 1'b1, ph(i), 0, (i == 0) ? 1'b0 : 1'b1, "R7", 1, x);
        end
        // Four-cycle delay from staggered clears (R7)
        for (int i = 0; i < 40; i++)
            step(0, (i == 0) ? 1'b0 : 1'b1, pk(i), 0, (i == 4) ? 1'b0 : 1'b1,
                 "R7", (i >= 4), (i >= 4) ? pk(i - 4) : 8'h00);
        // One-cycle lag: each read meets the commit of its address -> old byte (R6)
        for (int i = 0; i < 12; i++)
            step(0, (i == 0) ? 1'b0 : 1'b1, pm(i), 0, (i == 1) ? 1'b0 : 1'b1,
                 "R6", (i >= 1), (i >= 1) ? pk(i - 1) : 8'h00);
        // Two-cycle lag: shortest that returns the new byte (R6)
        for (int i = 0; i < 12; i++)
            step(0, (i == 0) ? 1'b0 : 1'b1, pk(i + 50), 0, (i == 2) ? 1'b0 : 1'b1,
                 "R6", (i >= 2), (i >= 2) ? pk(i + 48) : 8'h00);
        step(1, 1, 8'h00, 1, 1, "R4", 0, 8'h00);
        repeat (2) @(posedge clk);
        #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule